// File: doc/BRIEF.md
# Sound Unit Test-Mode Register Front End

This block sits between an 8-bit CPU bus and a five-channel sound unit. It adds a diagnostic register window that is active only while a test-enable pin is high. In that mode three addresses next to the controller-port window read back the instantaneous DAC level of every channel. A write to the last of the three addresses preloads the triangle sequencer step and sets a lock that freezes the channels. The sound channels themselves are outside this block. It only decodes, muxes and holds the lock.

The block also chooses when the external data bus is cut off from the internal bus during reads. In normal mode only the status register does this. In test mode the whole 32-byte sound/IO window does it, which is why controller reads stop working there. A clock-run enable tells the clock generator whether the CPU clock keeps toggling while reset is held.

Top module: `snd_testreg`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `lock_out` and `tri_load` are 0.
- R2: With `test_en` high, a read of 0x4018 returns `{dac_pulse2, dac_pulse1}` (pulse2 in bits 7:4, pulse1 in bits 3:0) on `rdata` in the same cycle.
- R3: With `test_en` high, a read of 0x4019 returns `{dac_noise, dac_tri}` (noise in bits 7:4, triangle in bits 3:0).
- R4: With `test_en` high, a read of 0x401A returns `{1'b0, dac_dpcm}`. Bit 7 is always 0.
- R5: `rdata` is 0x00 for any other read and for every read while `test_en` is low. This includes 0x401B to 0x401F in test mode.
- R6: A write to 0x401A with `test_en` high makes `tri_load` high for exactly the next cycle, with `tri_step` equal to write-data bits 4:0. It also stores write-data bit 7 as the lock. Bits 6:5 have no effect.
- R7: `lock_out` equals the stored lock ANDed with `test_en`. Dropping `test_en` forces it to 0, and the stored value is kept.
- R8: A write to 0x401A while `test_en` is low changes nothing: no `tri_load` pulse and no change to the stored lock.
- R9: `joy_rd` is high only for a read of 0x4016 or 0x4017 while `test_en` is low.
- R10: `bus_iso` is high in the read cycle for any address 0x4000 to 0x401F while `test_en` is high. While `test_en` is low it is high only for a read of 0x4015. It is 0 when no read is made.
- R11: `clk_run_en` is high whenever `rst_n` is high, or whenever `test_en` is high. It is low only while reset is held in normal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset (CPU reset) |
| test_en | input | 1 | Test-mode enable pin |
| addr | input | 16 | CPU address |
| wdata | input | 8 | CPU write data |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_en | input | 1 | Write strobe, one cycle per access |
| dac_pulse1 | input | 4 | Pulse 1 instant DAC level |
| dac_pulse2 | input | 4 | Pulse 2 instant DAC level |
| dac_noise | input | 4 | Noise instant DAC level |
| dac_tri | input | 4 | Triangle instant DAC level |
| dac_dpcm | input | 7 | Sample channel instant DAC level |
| rdata | output | 8 | Read data from the test registers |
| bus_iso | output | 1 | Isolate external data bus for this read |
| joy_rd | output | 1 | Controller-port read strobe |
| tri_load | output | 1 | One-cycle triangle step load |
| tri_step | output | 5 | Step value for the load |
| lock_out | output | 1 | Channel freeze lock (effective) |
| clk_run_en | output | 1 | Keep CPU clock running |

## Verification
The assertions assume that `rd_en` and `wr_en` are never high in the same cycle, and that `addr` and `test_en` hold steady across each strobe. The bench drives each access as a single-cycle strobe with every bus input set just after a clock edge. It changes `test_en` only between accesses. DAC inputs are changed only while no read is pending, so each read's expected value is fixed when the driver queues it.

// File: rtl/snd_tm_pkg.sv
package snd_tm_pkg;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int LVL_W  = 4;
  localparam int DPCM_W = 7;
  localparam int STEP_W = 5;

  localparam logic [ADDR_W-1:0] WIN_BASE    = 16'h4000;
  localparam int                WIN_SPAN    = 32;
  localparam logic [ADDR_W-1:0] STATUS_ADDR = 16'h4015;
  localparam logic [ADDR_W-1:0] JOY_ADDR0   = 16'h4016;
  localparam logic [ADDR_W-1:0] TST_PP_ADDR = 16'h4018;
  localparam logic [ADDR_W-1:0] TST_NT_ADDR = 16'h4019;
  localparam logic [ADDR_W-1:0] TST_DP_ADDR = 16'h401A;

  typedef struct packed {
    logic sel_pp;   // pulse pair readback
    logic sel_nt;   // noise/triangle readback
    logic sel_dp;   // sample channel readback
    logic wr_step;  // step/lock write
    logic iso;      // isolate external bus
    logic joy;      // controller read strobe
  } tm_dec_t;

  // Two levels side by side, high one in the upper half.
  function automatic logic [DATA_W-1:0] pack_pair(input logic [LVL_W-1:0] hi,
                                                  input logic [LVL_W-1:0] lo);
    return {hi, lo};
  endfunction

  // Zero-extend the sample channel level to a full byte.
  function automatic logic [DATA_W-1:0] widen_dpcm(input logic [DPCM_W-1:0] v);
    return {{(DATA_W-DPCM_W){1'b0}}, v};
  endfunction

  function automatic logic in_window(input logic [ADDR_W-1:0] a);
    return (a >= WIN_BASE) && (a < WIN_BASE + ADDR_W'(WIN_SPAN));
  endfunction
endpackage

// File: rtl/snd_tm_decode.sv
module snd_tm_decode
  import snd_tm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic              test_en,
  output tm_dec_t           dec
);
  logic win_hit, joy_hit;

  always_comb begin
    win_hit = in_window(addr);
    joy_hit = (addr == JOY_ADDR0) || (addr == JOY_ADDR0 + 16'd1);
    dec = '0;
    dec.sel_pp  = rd_en && test_en && (addr == TST_PP_ADDR);
    dec.sel_nt  = rd_en && test_en && (addr == TST_NT_ADDR);
    dec.sel_dp  = rd_en && test_en && (addr == TST_DP_ADDR);
    dec.wr_step = wr_en && test_en && (addr == TST_DP_ADDR);
    dec.joy     = rd_en && !test_en && joy_hit;
    dec.iso     = rd_en && (test_en ? win_hit : (addr == STATUS_ADDR));
  end

  assert_one_sel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dec.sel_pp, dec.sel_nt, dec.sel_dp}));
  assert_joy_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dec.joy |-> (!test_en && !dec.iso));
  assert_iso_normal_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dec.iso && !test_en) |-> (addr == STATUS_ADDR));
  assert_iso_covers_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dec.sel_pp || dec.sel_nt || dec.sel_dp) |-> dec.iso);
endmodule

// File: rtl/snd_tm_rdmux.sv
module snd_tm_rdmux
  import snd_tm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  tm_dec_t           dec,
  input  logic [LVL_W-1:0]  dac_pulse1,
  input  logic [LVL_W-1:0]  dac_pulse2,
  input  logic [LVL_W-1:0]  dac_noise,
  input  logic [LVL_W-1:0]  dac_tri,
  input  logic [DPCM_W-1:0] dac_dpcm,
  output logic [DATA_W-1:0] rdata
);
  always_comb begin
    rdata = '0;
    if (dec.sel_pp) rdata = pack_pair(dac_pulse2, dac_pulse1);
    if (dec.sel_nt) rdata = pack_pair(dac_noise, dac_tri);
    if (dec.sel_dp) rdata = widen_dpcm(dac_dpcm);
  end

  assert_data_needs_sel_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata != '0) |-> (dec.sel_pp || dec.sel_nt || dec.sel_dp));
  assert_dp_msb_R4: assert property (@(posedge clk) disable iff (!rst_n)
    dec.sel_dp |-> !rdata[DATA_W-1]);
endmodule

// File: rtl/snd_tm_ctrl.sv
module snd_tm_ctrl
  import snd_tm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              test_en,
  input  logic              wr_step,
  input  logic [STEP_W-1:0] step_in,
  input  logic              lock_in,
  output logic              tri_load,
  output logic [STEP_W-1:0] tri_step,
  output logic              lock_out
);
  logic lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q   <= 1'b0;
      tri_load <= 1'b0;
      tri_step <= '0;
    end else begin
      tri_load <= wr_step;
      if (wr_step) begin
        tri_step <= step_in;
        lock_q   <= lock_in;
      end
    end
  end

  assign lock_out = lock_q & test_en;

  assert_load_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_step |=> (tri_load && tri_step == $past(step_in)));
  assert_load_needs_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tri_load |-> $past(wr_step));
  assert_lock_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_step) |-> (lock_q == $past(lock_q)));
  assert_lock_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lock_out |-> test_en);
endmodule

// File: rtl/snd_testreg.sv
module snd_testreg
  import snd_tm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              test_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [LVL_W-1:0]  dac_pulse1,
  input  logic [LVL_W-1:0]  dac_pulse2,
  input  logic [LVL_W-1:0]  dac_noise,
  input  logic [LVL_W-1:0]  dac_tri,
  input  logic [DPCM_W-1:0] dac_dpcm,
  output logic [DATA_W-1:0] rdata,
  output logic              bus_iso,
  output logic              joy_rd,
  output logic              tri_load,
  output logic [STEP_W-1:0] tri_step,
  output logic              lock_out,
  output logic              clk_run_en
);
  tm_dec_t dec;
  logic    wdata_unused;

  // Bits between the step field and the lock bit carry nothing.
  assign wdata_unused = ^wdata[DATA_W-2:STEP_W];

  snd_tm_decode u_dec (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .test_en(test_en), .dec(dec)
  );

  snd_tm_rdmux u_mux (
    .clk(clk), .rst_n(rst_n), .dec(dec),
    .dac_pulse1(dac_pulse1), .dac_pulse2(dac_pulse2), .dac_noise(dac_noise),
    .dac_tri(dac_tri), .dac_dpcm(dac_dpcm), .rdata(rdata)
  );

  snd_tm_ctrl u_ctl (
    .clk(clk), .rst_n(rst_n), .test_en(test_en), .wr_step(dec.wr_step),
    .step_in(wdata[STEP_W-1:0]), .lock_in(wdata[DATA_W-1]),
    .tri_load(tri_load), .tri_step(tri_step), .lock_out(lock_out)
  );

  assign bus_iso    = dec.iso;
  assign joy_rd     = dec.joy;
  assign clk_run_en = rst_n | test_en;

  assert_clk_run_R11: assert property (@(posedge clk)
    !clk_run_en |-> (!test_en && !rst_n));
  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> (!lock_out && !tri_load));
endmodule

// File: tb/tb_snd_testreg.sv
module tb_snd_testreg;
  logic       clk = 0, rst_n = 0, test_en = 0, rd_en = 0, wr_en = 0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0, rdata;
  logic [3:0]  p1 = 0, p2 = 0, nz = 0, tr = 0;
  logic [6:0]  dp = 0;
  logic        bus_iso, joy_rd, tri_load, lock_out, clk_run_en;
  logic [4:0]  tri_step;
  int          n_run = 0, n_fail = 0;
  bit          done = 0;

  typedef struct { logic [15:0] a; logic [7:0] d; logic iso; logic joy; string tag; } item_t;
  item_t sb[$];

  always #5 clk = ~clk;

  snd_testreg dut (
    .clk(clk), .rst_n(rst_n), .test_en(test_en), .addr(addr), .wdata(wdata),
    .rd_en(rd_en), .wr_en(wr_en), .dac_pulse1(p1), .dac_pulse2(p2),
    .dac_noise(nz), .dac_tri(tr), .dac_dpcm(dp), .rdata(rdata),
    .bus_iso(bus_iso), .joy_rd(joy_rd), .tri_load(tri_load),
    .tri_step(tri_step), .lock_out(lock_out), .clk_run_en(clk_run_en)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Independent model of the readback map.
  function automatic logic [7:0] model_rd(input logic [15:0] a, input logic tm);
    if (!tm) return 8'h00;
    unique case (a)
      16'h4018: return (8'(p2) << 4) | 8'(p1);
      16'h4019: return (8'(nz) << 4) | 8'(tr);
      16'h401A: return 8'(dp);
      default:  return 8'h00;
    endcase
  endfunction

  task automatic do_read(input logic [15:0] a, input string tag);
    item_t it;
    it.a = a;
    it.d = model_rd(a, test_en);
    it.iso = test_en ? (a >= 16'h4000 && a <= 16'h401F) : (a == 16'h4015);
    it.joy = !test_en && (a == 16'h4016 || a == 16'h4017);
    it.tag = tag;
    sb.push_back(it);
    @(posedge clk); #1; addr = a; rd_en = 1;
    @(posedge clk); #1; rd_en = 0;
  endtask

  task automatic do_write(input logic [7:0] d, input bit exp_load,
                          input logic [4:0] exp_step, input bit exp_lock, input string tag);
    @(posedge clk); #1; addr = 16'h401A; wdata = d; wr_en = 1;
    @(posedge clk); #1; wr_en = 0;
    @(negedge clk);
    chk(tri_load == exp_load, {tag, " load"}, tri_load, exp_load);
    if (exp_load) chk(tri_step == exp_step, {tag, " step"}, tri_step, exp_step);
    chk(lock_out == exp_lock, {tag, " lock"}, lock_out, exp_lock);
    @(negedge clk);
    chk(tri_load == 1'b0, {tag, " pulse width"}, tri_load, 0);
  endtask

  // Monitor: compare every read cycle against the queued expectation.
  always @(negedge clk) begin
    if (rd_en && sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      chk(rdata == it.d, {it.tag, " rdata"}, rdata, it.d);
      chk(bus_iso == it.iso, {it.tag, " bus_iso"}, bus_iso, it.iso);
      chk(joy_rd == it.joy, {it.tag, " joy_rd"}, joy_rd, it.joy);
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(clk_run_en == 0, "R11 reset normal", clk_run_en, 0);
    chk(lock_out == 0 && tri_load == 0, "R1 reset state", {lock_out, tri_load}, 0);
    test_en = 1; #1;
    chk(clk_run_en == 1, "R11 reset test", clk_run_en, 1);
    @(posedge clk); #1; rst_n = 1;
    @(negedge clk);
    chk(lock_out == 0 && tri_load == 0, "R1 after release", {lock_out, tri_load}, 0);
    test_en = 0; #1;
    chk(clk_run_en == 1, "R11 running normal", clk_run_en, 1);
    test_en = 1;

    p1 = 4'h3; p2 = 4'hC; nz = 4'h9; tr = 4'hF; dp = 7'h55;
    do_read(16'h4018, "R2 pulse pair");
    do_read(16'h4019, "R3 noise/tri");
    do_read(16'h401A, "R4 dpcm");
    p1 = 4'h0; p2 = 4'hF; nz = 4'h0; tr = 4'h0; dp = 7'h7F;
    do_read(16'h4018, "R2 pulse pair b");
    do_read(16'h4019, "R3 noise/tri b");
    do_read(16'h401A, "R4 dpcm max");
    do_read(16'h401B, "R5 unmapped lo");
    do_read(16'h401F, "R5 unmapped hi");
    do_read(16'h4016, "R9 joy in test");
    do_read(16'h4000, "R10 window base");
    do_read(16'h4020, "R10 past window");
    do_read(16'h3FFF, "R10 below window");

    test_en = 0;
    do_read(16'h4015, "R10 status normal");
    do_read(16'h4016, "R9 joy0 normal");
    do_read(16'h4017, "R9 joy1 normal");
    do_read(16'h4018, "R5 test addr normal");
    do_read(16'h4000, "R10 window normal");
    @(negedge clk);
    chk(bus_iso == 0, "R10 idle", bus_iso, 0);

    test_en = 1;
    do_write(8'h9F, 1, 5'h1F, 1, "R6 write lock");
    do_write(8'h65, 1, 5'h05, 0, "R6 bits 6:5 ignored");
    do_write(8'hE3, 1, 5'h03, 1, "R6 lock again");
    test_en = 0; #1;
    chk(lock_out == 0, "R7 forced off", lock_out, 0);
    do_write(8'h0A, 0, 5'h00, 0, "R8 write ignored");
    test_en = 1; #1;
    chk(lock_out == 1, "R7 stored lock kept", lock_out, 1);
    @(negedge clk);
    chk(tri_step == 5'h03, "R8 step unchanged", tri_step, 3);

    repeat (2) @(posedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule